// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead Time

This block produces the two gate enables of a half-bridge from a free-running oscillator pulse. The oscillator is brought into the system clock domain, and only its falling edges matter. Each falling edge ends the side that is conducting. A fixed gap follows in which neither side conducts, and then the opposite side turns on. The bridge therefore runs at half the oscillator rate, and both sides get equal conduction time.

In reset, and whenever the run command is low, the bridge rests in a safe state: low side on, high side off. Two fault flags change the normal sequence. A bootstrap-low flag blocks the high-side enable while it is set. An over-current flag ends the present conduction pulse at once, and the bridge then waits with both sides off for the next oscillator edge. The non-overlap length is a parameter given in system-clock cycles. Its default is 120 cycles, which is 1.2 µs at 100 MHz.

Top module: `hb_gate_seq`

## Requirements
- R1: Only falling edges of `osc_in` move the bridge; rising edges have no effect. After a falling edge at the input, the conducting side turns off on the third rising clock edge. With a steady oscillator period, high and low side are each on for the same number of cycles per bridge period, which is two oscillator periods.
- R2: `hs_en_o` and `ls_en_o` are never both 1.
- R3: Between the end of one conduction phase and the start of the next, both enables stay 0 for exactly `DEAD_CYC` clock cycles.
- R4: While `rst_n` is low, and straight after its release, `ls_en_o` is 1 and `hs_en_o` is 0. Asserting `rst_n` takes effect without waiting for a clock edge.
- R5: After reset with `run_i` = 1, the first falling edge starts a dead gap that is followed by the high side.
- R6: With `run_i` = 0, a low-side phase continues as the parked state. A high-side phase ends in a full dead gap and then parks with the low side on. In the parked state, oscillator edges are ignored.
- R7: While `boot_low_i` = 1, `hs_en_o` is 0 from the next clock edge onward. The flag does not affect `ls_en_o` or the phase timing, and the high side comes back one cycle after the flag clears if its phase is still running.
- R8: When `ocp_i` = 1 during a conduction phase with `run_i` = 1, both enables go to 0 at the next clock edge. They stay 0 until the next falling edge, which starts a dead gap followed by the opposite side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside |
| osc_in | input | 1 | Oscillator pulse, asynchronous to `clk` |
| run_i | input | 1 | 1 = switch the bridge, 0 = park it |
| boot_low_i | input | 1 | Bootstrap supply below lockout; blocks the high side |
| ocp_i | input | 1 | Transistor over-current flag |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The hardest situations to reach from the ports are the fault interactions that must fall inside a specific phase. One case is an over-current cut during a high-side phase that resumes as low side only after a later edge. Another is a bootstrap flag that covers the end of a dead gap, so the high side must stay dark even though its phase has begun. The stimulus counts clock cycles from each oscillator edge it drives, allowing for the three-edge input latency and the dead length. Each flag is raised at a known offset inside the intended phase, and the expected state is sampled in the exact cycle where the phase should be active.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [2:0] {
    PH_PARK = 3'd0,
    PH_DEAD = 3'd1,
    PH_HIGH = 3'd2,
    PH_LOW  = 3'd3,
    PH_CUT  = 3'd4
  } phase_e;

  typedef enum logic {
    SIDE_HIGH = 1'b0,
    SIDE_LOW  = 1'b1
  } side_e;

endpackage

// File: rtl/hb_osc_edge.sv
module hb_osc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = osc_i;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], osc_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R1

endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
  parameter int DEAD_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic done_o
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = arm_i || (cnt_q != '0);
    cnt_d  = arm_i ? LOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R3

endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic run_i,
  input  logic boot_low_i,
  input  logic ocp_i,
  input  logic dead_done_i,
  output logic arm_o,
  output logic hs_o,
  output logic ls_o
);

  localparam int CW = $clog2(DEAD_CYC + 1);

  phase_e st_q, st_d;
  side_e  tgt_q, tgt_d;
  logic   hs_q, hs_d;
  logic   ls_q, ls_d;

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    case (st_q)
      PH_PARK: begin
        if (run_i && fall_i) begin
          st_d  = PH_DEAD;
          tgt_d = SIDE_HIGH;
        end
      end
      PH_DEAD: begin
        if (dead_done_i) begin
          if (!run_i)                  st_d = PH_PARK;
          else if (tgt_q == SIDE_HIGH) st_d = PH_HIGH;
          else                         st_d = PH_LOW;
        end
      end
      PH_HIGH: begin
        if (!run_i || fall_i) begin
          st_d  = PH_DEAD;
          tgt_d = SIDE_LOW;
        end else if (ocp_i) begin
          st_d  = PH_CUT;
          tgt_d = SIDE_LOW;
        end
      end
      PH_LOW: begin
        if (!run_i) begin
          st_d = PH_PARK;
        end else if (fall_i) begin
          st_d  = PH_DEAD;
          tgt_d = SIDE_HIGH;
        end else if (ocp_i) begin
          st_d  = PH_CUT;
          tgt_d = SIDE_HIGH;
        end
      end
      PH_CUT: begin
        if (!run_i) begin
          st_d  = PH_DEAD;
          tgt_d = SIDE_LOW;
        end else if (fall_i) begin
          st_d = PH_DEAD;
        end
      end
      default: begin
        st_d  = PH_PARK;
        tgt_d = SIDE_HIGH;
      end
    endcase
  end

  always_comb begin
    arm_o = (st_d == PH_DEAD) && (st_q != PH_DEAD);
    hs_d  = (st_d == PH_HIGH) && !boot_low_i;
    ls_d  = (st_d == PH_LOW) || (st_d == PH_PARK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_PARK;
      tgt_q <= SIDE_HIGH;
      hs_q  <= 1'b0;
      ls_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      hs_q  <= hs_d;
      ls_q  <= ls_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  // consecutive cycles with both enables low, saturating; used by AST_GAP_LEN
  logic [CW-1:0] off_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_q <= '0;
    end else if (hs_q || ls_q) begin
      off_run_q <= '0;
    end else if (off_run_q != CW'(DEAD_CYC)) begin
      off_run_q <= off_run_q + 1'b1;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q)); // R2
  AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_q) || $rose(ls_q)) |-> (off_run_q == CW'(DEAD_CYC))); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && hs_q) |=> !hs_q); // R6
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && st_q == PH_LOW) |=> ls_q); // R6
  AST_BOOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_low_i |=> !hs_q); // R7
  AST_OCP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_i && run_i && (st_q == PH_HIGH || st_q == PH_LOW)) |=> (!hs_q && !ls_q)); // R8

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int DEAD_CYC    = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  input  logic run_i,
  input  logic boot_low_i,
  input  logic ocp_i,
  output logic hs_en_o,
  output logic ls_en_o
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  osc_fall;
  logic                  dead_arm;
  logic                  dead_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  hb_osc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .osc_i  (osc_in),
    .fall_o (osc_fall)
  );

  hb_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .arm_i  (dead_arm),
    .done_o (dead_done)
  );

  hb_phase_fsm #(.DEAD_CYC(DEAD_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fall_i      (osc_fall),
    .run_i       (run_i),
    .boot_low_i  (boot_low_i),
    .ocp_i       (ocp_i),
    .dead_done_i (dead_done),
    .arm_o       (dead_arm),
    .hs_o        (hs_en_o),
    .ls_o        (ls_en_o)
  );

endmodule

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;

  localparam int DEAD = 12;

  logic clk = 1'b0;
  logic rst_n, osc_in, run_i, boot_low_i, ocp_i;
  logic hs_en_o, ls_en_o;

  int compared = 0;
  int mismatched = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_gate_seq #(.DEAD_CYC(DEAD)) i_hb_gate_seq (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .run_i(run_i),
    .boot_low_i(boot_low_i), .ocp_i(ocp_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );

  typedef struct packed {
    logic       osc;
    logic       run;
    logic       boot;
    logic       ocp;
    logic [7:0] wait_n;
    logic       hs;
    logic       ls;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd4,  1'b0, 1'b1, 4'd1},  // R1 rising edge ignored
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0, 4'd3},  // R3 gap begins
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd11, 1'b0, 1'b0, 4'd3},  // R3 last gap cycle
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0, 4'd5},  // R5 high side first
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd10, 1'b1, 1'b0, 4'd1},  // R1 rising edge ignored
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd12, 1'b0, 1'b1, 4'd1},  // R1 low side follows
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'd5,  1'b0, 1'b1, 4'd7},  // R7 low side unaffected
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd15, 1'b0, 1'b0, 4'd7},  // R7 high blocked
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0, 4'd7},  // R7 high resumes
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd1,  1'b0, 1'b0, 4'd8},  // R8 cut
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 1'b0, 1'b0, 4'd8},  // R8 stays cut
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  1'b0, 1'b0, 4'd8},  // R8 rising no exit
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd15, 1'b0, 1'b1, 4'd8},  // R8 opposite side
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  1'b0, 1'b1, 4'd6},  // R6 low parks
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'd5,  1'b0, 1'b1, 4'd6},  // R6
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b1, 4'd6},  // R6 edge ignored parked
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  1'b0, 1'b1, 4'd6},  // R6
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd15, 1'b1, 1'b0, 4'd6},  // R6 restart high
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 4'd6},  // R6 stop in high
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd11, 1'b0, 1'b0, 4'd6},  // R6 full gap
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1, 4'd6}   // R6 parked
  };

  task automatic check_bit(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic check_int(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && hs_en_o && ls_en_o) overlap++;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int k;
    int m;
    int hs_cnt;
    int ls_cnt;
    rst_n = 1'b0; osc_in = 1'b1; run_i = 1'b0; boot_low_i = 1'b0; ocp_i = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R4 reset hs", hs_en_o, 1'b0);
    check_bit("R4 reset ls", ls_en_o, 1'b1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_bit("R4 after release ls", ls_en_o, 1'b1);

    for (int i = 0; i < NV; i++) begin
      osc_in = TBL[i].osc; run_i = TBL[i].run;
      boot_low_i = TBL[i].boot; ocp_i = TBL[i].ocp;
      repeat (int'(TBL[i].wait_n)) @(negedge clk);
      compared++;
      if (hs_en_o !== TBL[i].hs || ls_en_o !== TBL[i].ls) begin
        mismatched++;
        $display("FAIL R%0d step %0d: actual hs=%0b ls=%0b expected hs=%0b ls=%0b",
                 TBL[i].req, i, hs_en_o, ls_en_o, TBL[i].hs, TBL[i].ls);
      end
    end

    // R1 latency and R3 gap length
    run_i = 1'b1; osc_in = 1'b1;
    repeat (5) @(negedge clk);
    osc_in = 1'b0;
    k = 0;
    while (ls_en_o && k < 50) begin @(negedge clk); k++; end
    check_int("R1 edge latency", k, 3);
    m = 0;
    while (!hs_en_o && m < 100) begin @(negedge clk); m++; end
    check_int("R3 gap cycles", m, DEAD);

    // R1 equal conduction per side
    hs_cnt = 0; ls_cnt = 0;
    for (int p = 0; p < 6; p++) begin
      osc_in = 1'b1;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (p >= 2) begin hs_cnt += int'(hs_en_o); ls_cnt += int'(ls_en_o); end
      end
      osc_in = 1'b0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (p >= 2) begin hs_cnt += int'(hs_en_o); ls_cnt += int'(ls_en_o); end
      end
    end
    check_int("R1 high-side cycles", hs_cnt, 2 * (60 - DEAD));
    check_int("R1 low-side cycles", ls_cnt, 2 * (60 - DEAD));

    // R4 asynchronous reset during high-side conduction
    m = 0;
    while (!hs_en_o && m < 200) begin
      osc_in = (m % 60) < 30;
      @(negedge clk); m++;
    end
    check_bit("R4 reached high before reset", hs_en_o, 1'b1);
    rst_n = 1'b0;
    #1;
    check_bit("R4 async hs off", hs_en_o, 1'b0);
    check_bit("R4 async ls on", ls_en_o, 1'b1);
    osc_in = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_bit("R4 parked after release", ls_en_o, 1'b1);
    // R5 first phase after reset is high
    osc_in = 1'b0;
    repeat (14) @(negedge clk);
    check_bit("R5 still in gap", hs_en_o | ls_en_o, 1'b0);
    @(negedge clk);
    check_bit("R5 high first", hs_en_o, 1'b1);

    check_int("R2 overlap cycles", overlap, 0);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule